// File: doc/BRIEF.md
# Non-Volatile Memory Clock Divider with Settled Flag

This block produces the slow clock used by a non-volatile memory interface from the bus clock. A 6-bit divider setting, written through a simple register port, sets the output period to the setting plus one bus-clock cycles. A setting of zero is not allowed to stop the clock. It is treated as a divide setting of 15, the value the block also uses after reset.

Software changes the memory clock before it raises the bus clock. The new setting never cuts short the output period already in progress. It takes over only at the next period boundary. A settled flag goes low as soon as a write changes the effective setting. It goes high again once one complete output period at the new setting has ended. Software polls that flag, through a dedicated output and through the read port, before it raises the bus frequency.

Top module: `nvm_clk_gen`

## Requirements
- R1: `rd_data[5:0]` returns the divider setting exactly as last written (reset value 0) and `rd_data[6]` mirrors `clk_ok`.
- R2: Once a setting is in effect, every output period on `clk_out` lasts exactly N+1 bus-clock cycles, where N is the effective setting.
- R3: Written values 1 to 63 are used as N unchanged; a written value of 0 makes N equal 15.
- R4: Within each period `clk_out` is high for the first ceil((N+1)/2) cycles and low for the rest, so odd periods spend the extra cycle high.
- R5: A new setting is adopted only at the end of the period in progress; that period finishes with its old length.
- R6: A write whose effective value differs from the current effective setting drives `clk_ok` low from the next cycle.
- R7: After a change, `clk_ok` returns high once a full period at the new setting has completed, and not earlier; a write that leaves the effective value unchanged does not affect `clk_ok`.
- R8: During and directly after reset `clk_out` is high, the effective setting is 15 and `clk_ok` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| wr_en | input | 1 | Write strobe for the divider setting |
| wr_data | input | 6 | New divider setting |
| rd_data | output | 7 | Stored setting in [5:0], settled flag in [6] |
| clk_out | output | 1 | Divided clock for the memory interface |
| clk_ok | output | 1 | High when the current setting is fully in effect |

## Verification
The assertions watch, on every cycle, that the period counter never passes the active setting, that the active setting holds still in the middle of a period and is never zero, that `clk_out` is high at the start of every period, that a changing write drops the settled flag on the next cycle, and that the flag rises only at a period boundary. Only the bench scenarios can show the exact high and low lengths for particular settings, the mapping of zero to 15, the full length of a period that is interrupted by a write, and the exact cycle at which the flag returns. The bench compares all of these cycle by cycle against a reference model through long random write sequences.

// File: rtl/nvm_clk_pkg.sv
package nvm_clk_pkg;
  localparam int unsigned DIV_W    = 6;
  localparam int unsigned DFLT_DIV = 15;

  typedef enum logic [1:0] {
    OK_IDLE  = 2'd0,
    OK_ADOPT = 2'd1,
    OK_FULL  = 2'd2
  } ok_state_t;
endpackage

// File: rtl/nvm_div_cfg.sv
module nvm_div_cfg #(
  parameter int unsigned DIV_W    = 6,
  parameter int unsigned DFLT_DIV = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] raw_q,
  output logic [DIV_W-1:0] eff_req,
  output logic             chg
);
  localparam logic [DIV_W-1:0] DFLT = DIV_W'(DFLT_DIV);

  logic [DIV_W-1:0] raw_d;
  logic [DIV_W-1:0] wr_eff;

  always_comb begin
    eff_req = (raw_q == '0) ? DFLT : raw_q;
    wr_eff  = (wr_data == '0) ? DFLT : wr_data;
    chg     = wr_en && (wr_eff != eff_req);
    raw_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else if (wr_en) raw_q <= raw_d;
  end

  a_r3_eff_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    eff_req != '0);
endmodule

// File: rtl/nvm_div_counter.sv
module nvm_div_counter #(
  parameter int unsigned DIV_W    = 6,
  parameter int unsigned DFLT_DIV = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] eff_req,
  output logic             wrap,
  output logic [DIV_W-1:0] active,
  output logic             clk_out
);
  localparam int unsigned HI_W = DIV_W + 1;

  logic [DIV_W-1:0] cnt_q, cnt_d, act_q, act_d;
  logic             act_en;
  logic             out_q, out_d;

  function automatic logic [HI_W-1:0] high_len(input logic [DIV_W-1:0] n);
    high_len = ({1'b0, n} + HI_W'(2)) >> 1;
  endfunction

  always_comb begin
    wrap   = (cnt_q == act_q);
    act_en = wrap;
    act_d  = act_en ? eff_req : act_q;
    cnt_d  = wrap ? '0 : cnt_q + DIV_W'(1);
    out_d  = ({1'b0, cnt_d} < high_len(act_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= DIV_W'(DFLT_DIV);
    else if (act_en) act_q <= act_d;
  end

  assign active  = act_q;
  assign clk_out = out_q;

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= act_q);
  a_r5_hold_midperiod: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != act_q) |=> $stable(act_q));
  a_r4_high_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> out_q);
endmodule

// File: rtl/nvm_ok_tracker.sv
module nvm_ok_tracker
  import nvm_clk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chg,
  input  logic wrap,
  output logic clk_ok
);
  ok_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (chg) begin
      st_d = OK_ADOPT;
    end else if (wrap) begin
      case (st_q)
        OK_ADOPT: st_d = OK_FULL;
        OK_FULL:  st_d = OK_IDLE;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= OK_IDLE;
    else        st_q <= st_d;
  end

  assign clk_ok = (st_q == OK_IDLE);

  a_r6_ok_drop: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !clk_ok);
  a_r7_ok_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_ok) |-> $past(wrap));
endmodule

// File: rtl/nvm_clk_gen.sv
module nvm_clk_gen
  import nvm_clk_pkg::*;
#(
  parameter int unsigned P_DIV_W    = DIV_W,
  parameter int unsigned P_DFLT_DIV = DFLT_DIV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [P_DIV_W-1:0] wr_data,
  output logic [P_DIV_W:0]   rd_data,
  output logic               clk_out,
  output logic               clk_ok
);
  logic [P_DIV_W-1:0] raw_q, eff_req, active;
  logic               chg, wrap;

  nvm_div_cfg #(.DIV_W(P_DIV_W), .DFLT_DIV(P_DFLT_DIV)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .raw_q(raw_q), .eff_req(eff_req), .chg(chg)
  );

  nvm_div_counter #(.DIV_W(P_DIV_W), .DFLT_DIV(P_DFLT_DIV)) cnt_i (
    .clk(clk), .rst_n(rst_n), .eff_req(eff_req),
    .wrap(wrap), .active(active), .clk_out(clk_out)
  );

  nvm_ok_tracker ok_i (
    .clk(clk), .rst_n(rst_n), .chg(chg), .wrap(wrap), .clk_ok(clk_ok)
  );

  assign rd_data = {clk_ok, raw_q};

  a_r1_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[P_DIV_W] == clk_ok);
  a_r7_ok_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ok |-> (active == eff_req));
endmodule

// File: tb/nvm_clk_gen_tb_top.sv
module nvm_clk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [5:0] wr_data;
  logic [6:0] rd_data;
  logic       clk_out, clk_ok;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit chk_en = 0;
  bit done = 0;

  // reference model state
  logic [5:0] m_raw, m_act, m_cnt;
  int         m_st;

  always #2 clk = ~clk;

  nvm_clk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out), .clk_ok(clk_ok)
  );

  function automatic logic [5:0] dec(input logic [5:0] v);
    return (v == 6'd0) ? 6'd15 : v;
  endfunction

  function automatic int high_len(input int n);
    return (n + 2) / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    logic [5:0] cur, weff;
    logic       wrp;
    int         nst;
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_raw = 6'd0; m_act = 6'd15; m_cnt = 6'd0; m_st = 0;
    end else begin
      cur  = dec(m_raw);
      weff = dec(wr_data);
      wrp  = (m_cnt == m_act);
      nst  = m_st;
      if (wr_en && weff != cur) nst = 1;
      else if (wrp) begin
        if (m_st == 1) nst = 2;
        else if (m_st == 2) nst = 0;
      end
      if (wrp) begin m_act = cur; m_cnt = 6'd0; end
      else m_cnt = m_cnt + 6'd1;
      if (wr_en) m_raw = wr_data;
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      chk("R2 R4 R5 clk_out", int'(clk_out), int'(int'(m_cnt) < high_len(int'(m_act))));
      chk("R6 R7 clk_ok", int'(clk_ok), int'(m_st == 0));
      chk("R1 rd_data", int'(rd_data), int'({m_st == 0, m_raw}));
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic write_val(input logic [5:0] v);
    logic changed;
    changed = (dec(v) != dec(rd_data[5:0]));
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
    if (changed) chk("R6 drop after write", int'(clk_ok), 0);
  endtask

  task automatic wait_ok();
    int guard = 0;
    while (!clk_ok && guard < 400) begin @(negedge clk); guard++; end
  endtask

  task automatic wait_rise();
    logic prev;
    prev = clk_out;
    @(negedge clk);
    while (!(clk_out && !prev)) begin prev = clk_out; @(negedge clk); end
  endtask

  // measure high length and period starting at a rising edge
  task automatic measure(output int hi, output int per);
    logic prev;
    wait_rise();
    hi = 1; per = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if (clk_out && !prev) break;
      if (clk_out) hi++;
      per++;
      prev = clk_out;
    end
  endtask

  task automatic directed(input logic [5:0] v, input string req);
    int hi, per, n;
    write_val(v);
    wait_ok();
    n = int'(dec(v));
    measure(hi, per);
    chk({req, " period"}, per, n + 1);
    chk({req, " high"}, hi, high_len(n));
  endtask

  initial begin
    int hi, per, p, gap;
    logic prev;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 6'd0;
    repeat (3) @(negedge clk);
    chk("R8 reset clk_out", int'(clk_out), 1);
    chk("R8 reset clk_ok", int'(clk_ok), 1);
    chk("R1 reset rd_data", int'(rd_data), 64);
    rst_n = 1'b1;
    @(negedge clk);
    chk_en = 1;

    // default setting 15: period 16, high 8
    measure(hi, per);
    chk("R8 default period", per, 16);
    chk("R8 default high", hi, 8);

    directed(6'd1,  "R2");
    directed(6'd63, "R2");
    directed(6'd6,  "R4 odd");
    directed(6'd7,  "R4 even");
    directed(6'd0,  "R3 zero");

    // R7: same effective value (15 stored as 0, write 15) keeps clk_ok
    write_val(6'd15);
    chk("R7 no-change keeps ok", int'(clk_ok), 1);
    chk("R1 raw stored", int'(rd_data[5:0]), 15);

    // R5: write mid-period, running period keeps old length
    write_val(6'd63);
    wait_ok();
    wait_rise();
    p = 0; prev = 1'b1;
    forever begin
      @(negedge clk); p++;
      if (p == 1) begin wr_en = 1'b1; wr_data = 6'd1; end
      if (p == 2) wr_en = 1'b0;
      if (clk_out && !prev) break;
      prev = clk_out;
    end
    chk("R5 interrupted period", p, 64);
    chk("R7 still low before full new period", int'(clk_ok), 0);
    repeat (3) @(negedge clk);
    chk("R7 high after full new period", int'(clk_ok), 1);

    // random writes against the model
    for (int i = 0; i < 300; i++) begin
      logic [5:0] v;
      case ($urandom % 5)
        0: v = 6'd0;
        1: v = 6'd15;
        2: v = 6'd1;
        default: v = 6'($urandom % 64);
      endcase
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
      gap = int'($urandom % 90);
      repeat (gap) @(negedge clk);
    end
    wait_ok();
    repeat (5) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule